// File: doc/BRIEF.md
# SIMD Predication Enable Stack

This block keeps the predication state of an array of SIMD processing elements. Each element holds a 32-bit shift register. Bit 0 of that register is the element's current enable flag. When the flag is low, the element's ordinary instructions must act as no-ops, so the flag gates register and memory writeback.

Nested conditional constructs drive the stack with four commands:

- **PUSH** (entering a construct) shifts the stack up and duplicates the current flag into bit 0.
- **POP** (leaving a construct) shifts it down and keeps the top bit.
- **CLEAR-IF-ZERO** clears the flag of every element whose tested register value is zero.
- **ENABLE-ALL** forces the flag high.

These commands update every element whether or not that element is enabled.

The array also produces two outputs for the control unit. One is a none-active summary, the NOR of all current flags. The other is a branch-taken signal for the jump-if-false instruction: it is asserted only when that command, once applied, leaves no element enabled.

Command decoding is the main control. The decoder maps the four one-hot command inputs to one of five named transitions:

- HOLD: no command, or more than one command asserted.
- PUSH
- POP
- CLRF: clear-if-zero.
- ALLEN: enable-all.

Each lane applies that transition to its own stack in a single `unique case`.

Top module: `simd_enable_stack`

## Requirements
- R1: After reset every stack bit of every element is 1, so `active_o` is all ones.
- R2: PUSH (`push_i` alone) sets each stack to {s[30:0], s[0]}; `active_o` is unchanged.
- R3: POP (`pop_i` alone) sets each stack to {s[31], s[31:1]}; repeated pops fill with the old bit 31.
- R4: CLRF (`clr_if_zero_i` alone) clears bit 0 of element i when its test value is zero and leaves it unchanged otherwise; bits 31..1 are unchanged.
- R5: ALLEN (`enable_all_i` alone) sets bit 0 of every element to 1; bits 31..1 are unchanged.
- R6: Every command updates an element even when that element's bit 0 is 0.
- R7: `none_active_o` is 1 exactly when every bit of `active_o` is 0.
- R8: `jumpf_taken_o` is 1 in a cycle exactly when CLRF is the command and, after its update, no element has bit 0 set; the signal is combinational from the current inputs.
- R9: With no command asserted (HOLD), every stack keeps its value.
- R10: With more than one command input asserted, the transition is HOLD: no stack changes and `jumpf_taken_o` is 0.
- R11: Element i uses test-value bits [i*DATA_W +: DATA_W] and drives `active_o[i]`; elements keep independent stacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | PUSH command |
| pop_i | input | 1 | POP command |
| clr_if_zero_i | input | 1 | CLRF command (jump-if-false) |
| enable_all_i | input | 1 | ALLEN command |
| test_val_i | input | NUM_PE*DATA_W | Per-element tested register values |
| active_o | output | NUM_PE | Current bit 0 of each element's stack |
| none_active_o | output | 1 | NOR of all current enable flags |
| jumpf_taken_o | output | 1 | Jump-if-false branch taken |

## Verification
Directed runs disable one element and then push and pop it past the 32-entry depth. This separates a correct duplicate-on-push and replicate-on-pop from a plain zero-filling shift, and from a design that skips updates on disabled elements. CLRF is applied with all-zero test values and with a single nonzero lane. This tells a correct post-update branch decision apart from one based on the old flags or on the wrong lane slice. Random command streams from a fixed seed also mix in idle cycles and illegal multi-command cycles, to confirm that HOLD really freezes the state.

// File: rtl/ens_pkg.sv
package ens_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_PUSH,
        CMD_POP,
        CMD_CLRF,
        CMD_ALLEN
    } ens_cmd_e;
endpackage

// File: rtl/ens_cmd_decode.sv
module ens_cmd_decode
    import ens_pkg::*;
(
    input  logic     push_i,
    input  logic     pop_i,
    input  logic     clr_i,
    input  logic     all_i,
    output ens_cmd_e cmd_o
);
    always_comb begin
        unique case ({push_i, pop_i, clr_i, all_i})
            4'b1000: cmd_o = CMD_PUSH;
            4'b0100: cmd_o = CMD_POP;
            4'b0010: cmd_o = CMD_CLRF;
            4'b0001: cmd_o = CMD_ALLEN;
            default: cmd_o = CMD_HOLD;   // idle or illegal combination
        endcase
    end
endmodule

// File: rtl/ens_lane.sv
module ens_lane
    import ens_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ens_cmd_e          cmd_i,
    input  logic [DATA_W-1:0] test_i,
    output logic              cur_o,
    output logic              nxt_o
);
    logic [DEPTH-1:0] stk_q, stk_d;
    logic             is_zero;

    assign is_zero = (test_i == '0);

    always_comb begin
        stk_d = stk_q;
        unique case (cmd_i)
            CMD_HOLD:  stk_d = stk_q;
            CMD_PUSH:  stk_d = {stk_q[DEPTH-2:0], stk_q[0]};
            CMD_POP:   stk_d = {stk_q[DEPTH-1], stk_q[DEPTH-1:1]};
            CMD_CLRF:  stk_d = {stk_q[DEPTH-1:1], stk_q[0] & ~is_zero};
            CMD_ALLEN: stk_d = {stk_q[DEPTH-1:1], 1'b1};
            default:   stk_d = stk_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '1;
        else        stk_q <= stk_d;
    end

    assign cur_o = stk_q[0];
    assign nxt_o = stk_d[0];
endmodule

// File: rtl/simd_enable_stack.sv
module simd_enable_stack
    import ens_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic                     clr_if_zero_i,
    input  logic                     enable_all_i,
    input  logic [NUM_PE*DATA_W-1:0] test_val_i,
    output logic [NUM_PE-1:0]        active_o,
    output logic                     none_active_o,
    output logic                     jumpf_taken_o
);
    ens_cmd_e          cmd;
    logic [NUM_PE-1:0] nxt_flags;

    ens_cmd_decode u_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .clr_i  (clr_if_zero_i),
        .all_i  (enable_all_i),
        .cmd_o  (cmd)
    );

    for (genvar g = 0; g < NUM_PE; g++) begin : g_lane
        ens_lane #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_i  (cmd),
            .test_i (test_val_i[g*DATA_W +: DATA_W]),
            .cur_o  (active_o[g]),
            .nxt_o  (nxt_flags[g])
        );
    end

    assign none_active_o = ~|active_o;
    assign jumpf_taken_o = (cmd == CMD_CLRF) && ~|nxt_flags;
endmodule

// File: rtl/simd_enable_stack_chk.sv
module simd_enable_stack_chk #(
    parameter int NUM_PE = 4,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     push_i,
    input logic                     pop_i,
    input logic                     clr_if_zero_i,
    input logic                     enable_all_i,
    input logic [NUM_PE*DATA_W-1:0] test_val_i,
    input logic [NUM_PE-1:0]        active_o,
    input logic                     none_active_o,
    input logic                     jumpf_taken_o
);
    logic [3:0]        cmds;
    logic [NUM_PE-1:0] zero_mask;
    logic              single, none_cmd, multi;

    assign cmds     = {push_i, pop_i, clr_if_zero_i, enable_all_i};
    assign single   = ($countones(cmds) == 1);
    assign none_cmd = (cmds == 4'b0000);
    assign multi    = ($countones(cmds) > 1);

    for (genvar g = 0; g < NUM_PE; g++) begin : g_z
        assign zero_mask[g] = (test_val_i[g*DATA_W +: DATA_W] == '0);
    end

    a_r2_push_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (single && push_i) |=> active_o == $past(active_o));

    a_r4_clrf_clears_zero_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (single && clr_if_zero_i) |=> active_o == ($past(active_o) & ~$past(zero_mask)));

    a_r5_allen_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
        (single && enable_all_i) |=> &active_o);

    a_r8_taken_means_none_next: assert property (@(posedge clk) disable iff (!rst_n)
        jumpf_taken_o |=> none_active_o);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        none_cmd |=> $stable(active_o));

    a_r10_multi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        multi |=> $stable(active_o));

    a_r10_multi_no_taken: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> !jumpf_taken_o);
endmodule

bind simd_enable_stack simd_enable_stack_chk #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .clr_if_zero_i (clr_if_zero_i),
    .enable_all_i  (enable_all_i),
    .test_val_i    (test_val_i),
    .active_o      (active_o),
    .none_active_o (none_active_o),
    .jumpf_taken_o (jumpf_taken_o)
);

// File: tb/simd_enable_stack_bench.sv
module simd_enable_stack_bench;
    localparam int NPE = 4;
    localparam int DW  = 16;
    localparam int DEP = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n, push, pop, clr, all;
    logic [NPE*DW-1:0] tv;
    logic [NPE-1:0]    active;
    logic              none_act, taken;

    simd_enable_stack #(.NUM_PE(NPE), .DEPTH(DEP), .DATA_W(DW)) u_simd_enable_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .clr_if_zero_i(clr), .enable_all_i(all), .test_val_i(tv),
        .active_o(active), .none_active_o(none_act), .jumpf_taken_o(taken)
    );

    int checks = 0;
    int errors = 0;
    logic [DEP-1:0] mdl [NPE];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DEP-1:0] nxt(logic [DEP-1:0] s, logic p, logic po,
                                           logic c, logic a, logic z);
        int n = int'(p) + int'(po) + int'(c) + int'(a);
        if (n != 1) return s;                                 // R9 R10
        if (p)  return {s[DEP-2:0], s[0]};                    // R2
        if (po) return {s[DEP-1], s[DEP-1:1]};                // R3
        if (c)  return z ? {s[DEP-1:1], 1'b0} : s;            // R4
        return {s[DEP-1:1], 1'b1};                            // R5
    endfunction

    function automatic logic [NPE*DW-1:0] mk_tv(logic [NPE-1:0] zm);
        logic [NPE*DW-1:0] v;
        for (int i = 0; i < NPE; i++)
            v[i*DW +: DW] = zm[i] ? '0 : (DW'($urandom) | DW'(1 << (i % DW)));
        return v;
    endfunction

    function automatic logic [NPE-1:0] mdl_flags();
        logic [NPE-1:0] f;
        for (int i = 0; i < NPE; i++) f[i] = mdl[i][0];
        return f;
    endfunction

    // entered just after a falling edge
    task automatic step(logic p, logic po, logic c, logic a, logic [NPE-1:0] zm, string tag);
        logic [DEP-1:0] nx [NPE];
        logic           all_off;
        int             n;
        push = p; pop = po; clr = c; all = a; tv = mk_tv(zm);
        #1;
        all_off = 1'b1;
        for (int i = 0; i < NPE; i++) begin
            nx[i] = nxt(mdl[i], p, po, c, a, zm[i]);
            if (nx[i][0]) all_off = 1'b0;
        end
        n = int'(p) + int'(po) + int'(c) + int'(a);
        chk(n > 1 ? "R10 taken" : "R8 taken", 32'(taken), 32'((n == 1) && c && all_off));
        @(posedge clk);
        for (int i = 0; i < NPE; i++) mdl[i] = nx[i];
        @(negedge clk);
        chk(tag, 32'(active), 32'(mdl_flags()));
        chk("R7 none_active", 32'(none_act), 32'(mdl_flags() == '0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(1234);
        rst_n = 0; push = 0; pop = 0; clr = 0; all = 0; tv = '0;
        for (int i = 0; i < NPE; i++) mdl[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset active", 32'(active), 32'({NPE{1'b1}}));
        chk("R1 reset none", 32'(none_act), 32'(0));

        // R3: pops from reset keep ones
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, '0, "R3 pop from reset");
        // R4/R11: clear lane 0 and lane 2 only
        step(0, 0, 1, 0, 4'b0101, "R4 R11 lane clear");
        // R6/R2: disabled lanes still push, deeper than the stack
        for (int k = 0; k < DEP + 3; k++) step(1, 0, 0, 0, '0, "R2 R6 push");
        step(0, 0, 0, 1, '0, "R5 allen");
        // R3: pops past depth replicate bit 31 (zeros for lanes 0,2)
        for (int k = 0; k < DEP + 3; k++) step(0, 1, 0, 0, '0, "R3 R6 pop");
        step(0, 0, 0, 1, '0, "R5 allen");
        step(0, 0, 0, 0, '1, "R9 idle");
        step(1, 1, 0, 0, '1, "R10 multi");
        step(0, 1, 1, 1, '1, "R10 multi");
        step(0, 0, 1, 0, 4'b1011, "R8 one lane survives");
        step(0, 0, 1, 0, 4'b1111, "R8 all cleared");
        step(0, 0, 1, 1, 4'b1111, "R10 multi with clear");
        step(0, 0, 0, 1, '0, "R5 allen");

        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom % 100);
            logic [NPE-1:0] zm = NPE'($urandom) & NPE'($urandom);
            if      (r < 25) step(1, 0, 0, 0, zm, "R2 random push");
            else if (r < 50) step(0, 1, 0, 0, zm, "R3 random pop");
            else if (r < 75) step(0, 0, 1, 0, zm, "R4 random clear");
            else if (r < 85) step(0, 0, 0, 1, zm, "R5 random allen");
            else if (r < 93) step(0, 0, 0, 0, zm, "R9 random idle");
            else step(1'($urandom), 1, 1'($urandom), 1, zm, "R10 random multi");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule